// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host bus that writes one 32-bit dword per cycle and a bank of 128-bit control registers. A single shared collector gathers the dwords of one wide register at a time. A normal wide register is committed to the bank only when all four of its dwords are present. The two write-only descriptor-pointer registers of each queue page behave differently. Writing their top dword always commits. Any low dwords that were not collected are committed as zero.

Each queue owns one page of registers. A byte address is split into a page number and an in-page offset. The page stride is selected by an input: 0x2000 or 0x10000 bytes. Two plain 32-bit registers per page bypass the collector and are passed straight to the register bank. One of them, the timer command register, empties the collector when it is written in page 0. The register bank lies outside this block. The block drives a one-cycle commit strobe carrying the page, the register kind and the 128-bit value, and a one-cycle narrow-write strobe for the 32-bit registers.

Top module: `wide_reg_collector`

## Requirements
- R1: After reset, neither strobe is asserted and the collector is empty. A descriptor-pointer top-dword write made first after reset therefore commits with bits 95:0 zero.
- R2: A normal wide register (in-page offset 0x100, kind code 0) commits only on the write that supplies the last missing dword, in any order. The commit appears one cycle after that write. Data is {dw3,dw2,dw1,dw0}, with dword n at byte offset +4n. A repeated write to the same dword overwrites the earlier value.
- R3: A write to the top dword (+12) of a descriptor-pointer register always commits that register. The pointer registers sit at offset 0x830 (kind code 1) and at offset 0xa10 (kind code 2). If dwords 0 to 2 of the same register were collected beforehand, the full 128-bit value is committed.
- R4: A descriptor-pointer commit that lacks any of dwords 0 to 2 carries the written top dword in bits 127:96 and zero in bits 95:0. Writes to dwords 0 to 2 of a pointer register never commit on their own.
- R5: While the collector holds a partial register, a write to a dword of a different wide register is discarded and the collector is left unchanged. This applies to every such write except a pointer top-dword write.
- R6: A pointer top-dword write that arrives while the collector holds a different register commits the pointer zero-filled. The collector keeps its contents.
- R7: A byte address decodes to page = address / stride and offset = address mod stride. The stride is 0x2000 when stride_mode=0 and 0x10000 when stride_mode=1. The write is ignored, with no strobe and no collector change, when the page is NUM_PAGES or above, when the address is not dword-aligned, or when the offset maps to no register.
- R8: A write to a 32-bit register produces nw_valid one cycle later with the page, the data and nw_sel. nw_sel is 0 for offset 0x400 and 1 for offset 0x420, the timer command register. Such a write does not disturb the collector, except in the case covered by R9.
- R9: A timer command write (offset 0x420) in page 0 empties the collector. The same write in any other page leaves the collector untouched.
- R10: Each commit strobe lasts one cycle per committing write. After a commit the collector is empty, so the next register needs all of its dwords again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stride_mode | input | 1 | Page stride select: 0 gives 0x2000, 1 gives 0x10000 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (18) | Host byte address |
| wr_data | input | 32 | Host write dword |
| cm_valid | output | 1 | Wide register commit strobe |
| cm_page | output | PAGE_W (2) | Page of the committed register |
| cm_kind | output | 2 | Committed register kind: 0 normal, 1 pointer at 0x830, 2 pointer at 0xa10 |
| cm_data | output | 128 | Committed 128-bit value |
| nw_valid | output | 1 | 32-bit register write strobe |
| nw_page | output | PAGE_W (2) | Page of the 32-bit write |
| nw_sel | output | 1 | 0 for offset 0x400, 1 for timer command at 0x420 |
| nw_data | output | 32 | 32-bit write data |

## Verification
The collector's mask and owner are visible at the ports only through the timing and content of commits. A corrupted mask shows as a commit that comes one write early, or that never comes. A wrong owner shows as an accepted interleaved write, and so as wrong dwords in a later commit. A bad zero-fill shows in cm_data one cycle after the top-dword write. Each scenario therefore follows every suspect write, whether discarded, ignored or invalidating, with the writes that finish the register the collector should still hold. The commit that results, or the lack of one, shows whether the collector state survived.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

    typedef enum logic [1:0] {
        WK_NORM = 2'd0,
        WK_PTRA = 2'd1,
        WK_PTRB = 2'd2
    } wide_kind_e;

    typedef enum logic [1:0] {
        AC_NONE   = 2'd0,
        AC_WIDE   = 2'd1,
        AC_NARROW = 2'd2
    } acc_class_e;

    typedef struct packed {
        acc_class_e cls;
        wide_kind_e kind;
        logic [1:0] dw;
        logic       nsel;
    } dec_t;

    localparam logic [15:0] OFF_NORM = 16'h0100;
    localparam logic [15:0] OFF_PTRA = 16'h0830;
    localparam logic [15:0] OFF_PTRB = 16'h0a10;
    localparam logic [15:0] OFF_EVQ  = 16'h0400;
    localparam logic [15:0] OFF_TMR  = 16'h0420;

    localparam int SHIFT_SMALL = 13;
    localparam int SHIFT_LARGE = 16;

    localparam int DW_W    = 32;
    localparam int NUM_DW  = 4;
    localparam int WIDE_W  = DW_W * NUM_DW;

    function automatic logic is_ptr(input wide_kind_e k);
        return (k == WK_PTRA) || (k == WK_PTRB);
    endfunction

endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_W    = 2,
    parameter int ADDR_W    = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              stride_mode,
    output dec_t              dec,
    output logic [PAGE_W-1:0] page
);

    logic [ADDR_W-1:0] pg_full;
    logic [15:0]       off;
    logic              in_range;

    always_comb begin
        if (stride_mode) begin
            pg_full = addr >> SHIFT_LARGE;
            off     = addr[15:0];
        end else begin
            pg_full = addr >> SHIFT_SMALL;
            off     = {3'b000, addr[12:0]};
        end
        in_range = pg_full < ADDR_W'(NUM_PAGES);
        page     = pg_full[PAGE_W-1:0];

        dec      = '{cls: AC_NONE, kind: WK_NORM, dw: off[3:2], nsel: 1'b0};
        if (in_range && off[1:0] == 2'b00) begin
            if (off[15:4] == OFF_NORM[15:4]) begin
                dec.cls  = AC_WIDE;
                dec.kind = WK_NORM;
            end else if (off[15:4] == OFF_PTRA[15:4]) begin
                dec.cls  = AC_WIDE;
                dec.kind = WK_PTRA;
            end else if (off[15:4] == OFF_PTRB[15:4]) begin
                dec.cls  = AC_WIDE;
                dec.kind = WK_PTRB;
            end else if (off == OFF_EVQ) begin
                dec.cls  = AC_NARROW;
            end else if (off == OFF_TMR) begin
                dec.cls  = AC_NARROW;
                dec.nsel = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
    import wrc_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic                 inval,
    input  logic [PAGE_W-1:0]    page,
    input  wide_kind_e           kind,
    input  logic [1:0]           dw,
    input  logic [DW_W-1:0]      data,
    output logic                 cm_valid,
    output logic [PAGE_W-1:0]    cm_page,
    output wide_kind_e           cm_kind,
    output logic [WIDE_W-1:0]    cm_data,
    output logic [NUM_DW-1:0]    mask_o
);

    localparam logic [NUM_DW-1:0] FULL = '1;

    logic [NUM_DW-1:0]            mask, mask_n, m_new;
    logic [PAGE_W-1:0]            own_page, own_page_n;
    wide_kind_e                   own_kind, own_kind_n;
    logic [NUM_DW-1:0][DW_W-1:0]  words, words_n, w_new;
    logic                         commit_n;
    logic [WIDE_W-1:0]            cdata_n;
    logic                         owner_ok, top_ptr;

    always_comb begin
        owner_ok   = (mask == '0) || (own_page == page && own_kind == kind);
        top_ptr    = is_ptr(kind) && (dw == 2'd3);
        m_new      = mask | (NUM_DW'(1) << dw);
        w_new      = words;
        w_new[dw]  = data;

        mask_n     = mask;
        words_n    = words;
        own_page_n = own_page;
        own_kind_n = own_kind;
        commit_n   = 1'b0;
        cdata_n    = '0;

        if (inval) begin
            mask_n = '0;
        end else if (fire) begin
            if (top_ptr && !owner_ok) begin
                commit_n = 1'b1;
                cdata_n  = {data, {(WIDE_W-DW_W){1'b0}}};
            end else if (owner_ok) begin
                if (top_ptr) begin
                    commit_n = 1'b1;
                    cdata_n  = (m_new == FULL) ? w_new
                                               : {data, {(WIDE_W-DW_W){1'b0}}};
                    mask_n   = '0;
                end else if (!is_ptr(kind) && m_new == FULL) begin
                    commit_n = 1'b1;
                    cdata_n  = w_new;
                    mask_n   = '0;
                end else begin
                    mask_n     = m_new;
                    words_n    = w_new;
                    own_page_n = page;
                    own_kind_n = kind;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '0;
            words    <= '0;
            own_page <= '0;
            own_kind <= WK_NORM;
            cm_valid <= 1'b0;
            cm_page  <= '0;
            cm_kind  <= WK_NORM;
            cm_data  <= '0;
        end else begin
            mask     <= mask_n;
            words    <= words_n;
            own_page <= own_page_n;
            own_kind <= own_kind_n;
            cm_valid <= commit_n;
            if (commit_n) begin
                cm_page <= page;
                cm_kind <= kind;
                cm_data <= cdata_n;
            end
        end
    end

    assign mask_o = mask;

endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter  int NUM_PAGES = 4,
    localparam int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int ADDR_W    = PAGE_W + SHIFT_LARGE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stride_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              cm_valid,
    output logic [PAGE_W-1:0] cm_page,
    output logic [1:0]        cm_kind,
    output logic [127:0]      cm_data,
    output logic              nw_valid,
    output logic [PAGE_W-1:0] nw_page,
    output logic              nw_sel,
    output logic [31:0]       nw_data
);

    dec_t              dec;
    logic [PAGE_W-1:0] dec_page;
    logic              wide_fire, narrow_fire, tmr_inval;
    wide_kind_e        cm_kind_e;
    logic [NUM_DW-1:0] coll_mask;

    wrc_decode #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_W    (PAGE_W),
        .ADDR_W    (ADDR_W)
    ) dec_i (
        .addr        (wr_addr),
        .stride_mode (stride_mode),
        .dec         (dec),
        .page        (dec_page)
    );

    assign wide_fire   = wr_en && (dec.cls == AC_WIDE);
    assign narrow_fire = wr_en && (dec.cls == AC_NARROW);
    assign tmr_inval   = narrow_fire && dec.nsel && (dec_page == '0);

    wrc_collector #(
        .PAGE_W (PAGE_W)
    ) coll_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (wide_fire),
        .inval    (tmr_inval),
        .page     (dec_page),
        .kind     (dec.kind),
        .dw       (dec.dw),
        .data     (wr_data),
        .cm_valid (cm_valid),
        .cm_page  (cm_page),
        .cm_kind  (cm_kind_e),
        .cm_data  (cm_data),
        .mask_o   (coll_mask)
    );

    assign cm_kind = cm_kind_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            nw_valid <= 1'b0;
            nw_page  <= '0;
            nw_sel   <= 1'b0;
            nw_data  <= '0;
        end else begin
            nw_valid <= narrow_fire;
            if (narrow_fire) begin
                nw_page <= dec_page;
                nw_sel  <= dec.nsel;
                nw_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              cm_valid,
    input logic [1:0]        cm_kind,
    input logic [127:0]      cm_data,
    input logic              nw_valid,
    input logic              nw_sel,
    input logic [PAGE_W-1:0] nw_page,
    input logic [3:0]        coll_mask
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !cm_valid && !nw_valid); // R1

    AST_CM_CAUSED: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> $past(wr_en)); // R10

    AST_NORM_LAST_DW: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cm_kind == 2'd0) |-> $countones($past(coll_mask)) == 3); // R2

    AST_PTR_FULL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && cm_kind != 2'd0 && cm_data[95:0] != '0) |-> $past(coll_mask) == 4'b0111); // R4

    AST_NW_CAUSED: assert property (@(posedge clk) disable iff (rst)
        nw_valid |-> $past(wr_en)); // R8

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(cm_valid && nw_valid)); // R8

    AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (nw_valid && nw_sel && nw_page == '0) |-> coll_mask == 4'b0000); // R9

    AST_MASK_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && $past(coll_mask) != 4'b0000 && cm_data[95:0] != '0) |-> $countones(coll_mask) <= 1); // R10

endmodule

bind wide_reg_collector wrc_checker #(.PAGE_W(PAGE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .cm_valid  (cm_valid),
    .cm_kind   (cm_kind),
    .cm_data   (cm_data),
    .nw_valid  (nw_valid),
    .nw_sel    (nw_sel),
    .nw_page   (nw_page),
    .coll_mask (coll_mask)
);

// File: tb/wide_reg_collector_tb_top.sv
module wide_reg_collector_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stride_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [17:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         cm_valid;
    logic [1:0]   cm_page;
    logic [1:0]   cm_kind;
    logic [127:0] cm_data;
    logic         nw_valid;
    logic [1:0]   nw_page;
    logic         nw_sel;
    logic [31:0]  nw_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wide_reg_collector #(.NUM_PAGES(4)) dut_i (
        .clk(clk), .rst(rst), .stride_mode(stride_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cm_valid(cm_valid), .cm_page(cm_page), .cm_kind(cm_kind), .cm_data(cm_data),
        .nw_valid(nw_valid), .nw_page(nw_page), .nw_sel(nw_sel), .nw_data(nw_data)
    );

    function automatic logic [17:0] adr(input int pg, input int off);
        int stride;
        stride = stride_mode ? 32'h10000 : 32'h2000;
        return 18'(pg * stride + off);
    endfunction

    function automatic int base_of(input int kd);
        return (kd == 0) ? 32'h100 : (kd == 1) ? 32'h830 : 32'ha10;
    endfunction

    function automatic logic [31:0] pat(input int salt, input int pg, input int kd, input int dw);
        return 32'hC000_0000 | (salt << 20) | (pg << 12) | (kd << 8) | dw;
    endfunction

    task automatic wr(input logic [17:0] a, input logic [31:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wwide(input int pg, input int kd, input int dw, input logic [31:0] d);
        wr(adr(pg, base_of(kd) + 4 * dw), d);
    endtask

    task automatic exp_none(input string tag);
        n_run++;
        if (cm_valid || nw_valid) begin
            n_fail++;
            $display("FAIL %s: got cm_valid=%0d nw_valid=%0d expected 0 0", tag, cm_valid, nw_valid);
        end
    endtask

    task automatic exp_cm(input string tag, input int pg, input int kd, input logic [127:0] d);
        n_run++;
        if (!cm_valid || nw_valid || cm_page != 2'(pg) || cm_kind != 2'(kd) || cm_data != d) begin
            n_fail++;
            $display("FAIL %s: got v=%0d pg=%0d kd=%0d data=%h expected v=1 pg=%0d kd=%0d data=%h",
                     tag, cm_valid, cm_page, cm_kind, cm_data, pg, kd, d);
        end
    endtask

    task automatic exp_nw(input string tag, input int pg, input bit sel, input logic [31:0] d);
        n_run++;
        if (!nw_valid || cm_valid || nw_page != 2'(pg) || nw_sel != sel || nw_data != d) begin
            n_fail++;
            $display("FAIL %s: got v=%0d pg=%0d sel=%0d data=%h expected v=1 pg=%0d sel=%0d data=%h",
                     tag, nw_valid, nw_page, nw_sel, nw_data, pg, sel, d);
        end
    endtask

    task automatic full4(input int salt, input int pg, input int kd, output logic [127:0] v);
        v = {pat(salt, pg, kd, 3), pat(salt, pg, kd, 2), pat(salt, pg, kd, 1), pat(salt, pg, kd, 0)};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        int order [4];
        order = '{3, 0, 2, 1};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_none("R1 reset quiet");
        wwide(0, 1, 3, 32'h1234_5678);
        exp_cm("R1 empty after reset", 0, 1, {32'h1234_5678, 96'h0});

        for (int m = 0; m < 2; m++) begin
            stride_mode = 1'(m);
            for (int pg = 0; pg < 4; pg++) begin
                full4(m, pg, 0, v);
                for (int i = 0; i < 3; i++) begin
                    wwide(pg, 0, order[i], pat(m, pg, 0, order[i]));
                    exp_none("R2 partial normal");
                end
                wwide(pg, 0, order[3], pat(m, pg, 0, order[3]));
                exp_cm("R2 R7 normal commit", pg, 0, v);
                @(negedge clk);
                exp_none("R10 strobe one cycle");
            end
        end

        stride_mode = 1'b0;
        wwide(1, 0, 0, 32'hDEAD_0000);
        wwide(1, 0, 0, pat(5, 1, 0, 0));
        wwide(1, 0, 1, pat(5, 1, 0, 1));
        wwide(1, 0, 2, pat(5, 1, 0, 2));
        exp_none("R2 overwrite no commit");
        wwide(1, 0, 3, pat(5, 1, 0, 3));
        full4(5, 1, 0, v);
        exp_cm("R2 overwrite last value", 1, 0, v);

        for (int m = 0; m < 2; m++) begin
            stride_mode = 1'(m);
            for (int pg = 0; pg < 4; pg++) begin
                for (int kd = 1; kd < 3; kd++) begin
                    for (int sub = 0; sub < 8; sub++) begin
                        for (int d = 0; d < 3; d++) begin
                            if (sub[d]) begin
                                wwide(pg, kd, d, pat(sub, pg, kd, d));
                                exp_none("R4 low pointer dword no commit");
                            end
                        end
                        wwide(pg, kd, 3, pat(sub, pg, kd, 3));
                        if (sub == 7) begin
                            full4(sub, pg, kd, v);
                            exp_cm("R3 pointer full commit", pg, kd, v);
                        end else begin
                            exp_cm("R4 pointer zero fill", pg, kd, {pat(sub, pg, kd, 3), 96'h0});
                        end
                    end
                end
            end
        end

        stride_mode = 1'b1;
        wwide(1, 0, 0, pat(9, 1, 0, 0));
        wwide(1, 0, 1, pat(9, 1, 0, 1));
        wwide(2, 0, 0, 32'hBAD0_0000);
        exp_none("R5 discard other normal");
        wwide(1, 1, 0, 32'hBAD0_0001);
        exp_none("R5 discard other pointer");
        wwide(1, 0, 2, pat(9, 1, 0, 2));
        wwide(1, 0, 3, pat(9, 1, 0, 3));
        full4(9, 1, 0, v);
        exp_cm("R5 original survives", 1, 0, v);
        wwide(2, 0, 1, pat(10, 2, 0, 1));
        wwide(2, 0, 2, pat(10, 2, 0, 2));
        wwide(2, 0, 3, pat(10, 2, 0, 3));
        exp_none("R5 discarded dword missing");
        wwide(2, 0, 0, pat(10, 2, 0, 0));
        full4(10, 2, 0, v);
        exp_cm("R5 commit after resupply", 2, 0, v);

        wwide(0, 0, 0, pat(11, 0, 0, 0));
        wwide(0, 0, 1, pat(11, 0, 0, 1));
        wwide(3, 2, 3, 32'h7777_0003);
        exp_cm("R6 foreign pointer top commits", 3, 2, {32'h7777_0003, 96'h0});
        wr(adr(2, 32'h400), 32'h0EE0_0002);
        exp_nw("R8 narrow write", 2, 1'b0, 32'h0EE0_0002);
        wwide(0, 0, 2, pat(11, 0, 0, 2));
        wwide(0, 0, 3, pat(11, 0, 0, 3));
        full4(11, 0, 0, v);
        exp_cm("R6 R8 collector kept", 0, 0, v);

        stride_mode = 1'b0;
        for (int d = 0; d < 3; d++) wwide(0, 0, d, pat(12, 0, 0, d));
        wr(adr(1, 32'h420), 32'h0000_0111);
        exp_nw("R9 timer page1 strobe", 1, 1'b1, 32'h0000_0111);
        wwide(0, 0, 3, pat(12, 0, 0, 3));
        full4(12, 0, 0, v);
        exp_cm("R9 timer page1 keeps collector", 0, 0, v);
        for (int d = 0; d < 3; d++) wwide(0, 0, d, pat(13, 0, 0, d));
        wr(adr(0, 32'h420), 32'h0000_0222);
        exp_nw("R9 timer page0 strobe", 0, 1'b1, 32'h0000_0222);
        wwide(0, 0, 3, pat(14, 0, 0, 3));
        exp_none("R9 timer page0 cleared");
        for (int d = 0; d < 2; d++) wwide(0, 0, d, pat(14, 0, 0, d));
        exp_none("R9 refill partial");
        wwide(0, 0, 2, pat(14, 0, 0, 2));
        full4(14, 0, 0, v);
        exp_cm("R9 refill commit", 0, 0, v);

        wwide(3, 0, 0, pat(15, 3, 0, 0));
        wwide(3, 0, 1, pat(15, 3, 0, 1));
        wwide(3, 0, 2, pat(15, 3, 0, 2));
        wr(18'(4 * 32'h2000 + 32'h10c), 32'hBAD1_0000);
        exp_none("R7 page out of range");
        wr(18'(8 * 32'h2000 + 32'h83c), 32'hBAD1_0001);
        exp_none("R7 large-stride address in small mode");
        wr(adr(3, 32'h10e), 32'hBAD1_0002);
        exp_none("R7 unaligned");
        wr(adr(3, 32'h200), 32'hBAD1_0003);
        exp_none("R7 unmapped offset");
        wwide(3, 0, 3, pat(15, 3, 0, 3));
        full4(15, 3, 0, v);
        exp_cm("R7 ignored writes left collector", 3, 0, v);
        for (int d = 0; d < 3; d++) begin
            wwide(3, 0, d, pat(16, 3, 0, d));
            exp_none("R10 collector empty after commit");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule